// File: doc/BRIEF.md
# PHY Management Register Bridge

This block gives host software one 32-bit register for reaching the 16-bit management registers of an external PHY. The host writes the register once to start a transaction. The register's top bit then acts as a completion flag. Its polarity depends on the direction. A write request sets the flag, and the hardware clears it once the write frame has gone out. A read request clears the flag, and the hardware sets it once the returned data sits in the low half of the register.

Behind the register is a serial management master. It drives a divided clock and one data line with an output enable. Each transaction is a complete 64-bit frame addressed to a fixed PHY address, set by a parameter that defaults to 1. Software polls the flag with a bounded loop, so every accepted request finishes after a fixed number of clocks.

Top module: `phy_mgmt_bridge`

## Requirements
- R1: After reset, the register reads as zero, the management clock is low and the data line is not driven.
- R2: The register reads back as {flag, ten zero bits, 5-bit register address in bits 20:16, 16-bit data in bits 15:0}.
- R3: A host write with bit 31 set starts a PHY write. The flag reads 1 from the next cycle and returns to 0 when the frame ends.
- R4: A host write with bit 31 clear starts a PHY read. The flag reads 0 from the next cycle and becomes 1 when the read data is in bits 15:0.
- R5: Each frame, sampled on rising management clock edges, is 32 ones, then 01, then an opcode (01 for write, 10 for read), then the PHY address (1), then the 5-bit register address, then a turnaround (10 for write), then 16 data bits MSB first.
- R6: For a read, the data line is released from the first turnaround bit through the last data bit. The 16 bits returned by the PHY are taken on rising management clock edges, MSB first.
- R7: The management clock has a period of CLK_DIV system clocks with equal halves, and it stays low when idle. The data output changes only on a falling management clock edge.
- R8: A host write that arrives while a transaction is in progress is ignored. The address, the flag and the frame on the line are unaffected.
- R9: The flag settles exactly 64*CLK_DIV clocks after the clock edge that accepted the request, and not one clock earlier.
- R10: A new request issued in the cycle right after completion is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe for the access register |
| host_wdata | input | 32 | Host write data (bit 31 direction, 20:16 address, 15:0 data) |
| host_rdata | output | 32 | Current register contents including the flag |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Drive enable for the management data line |
| mdio_i | input | 1 | Management data in from the PHY |

## Verification
The hardest case to reach is a host write that lands in the middle of a frame. The stimulus issues a second request about a hundred clocks after a PHY write has started. The bench then confirms three things: the register's upper half is unchanged, the original data completes, and no extra frame ever appears on the line. A behavioural PHY in the bench answers read frames bit by bit on falling clock edges. This shows that the design captures the returned value, including patterns with only the MSB and LSB set.

// File: rtl/phy_mgmt_bridge.sv
module phy_mgmt_bridge #(
  parameter int          CLK_DIV  = 8,
  parameter logic [4:0]  PHY_ADDR = 5'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int HALF     = CLK_DIV / 2;
  localparam int HW       = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int LAST_BIT = 63;
  localparam int TA_BIT   = 46;
  localparam int DAT_BIT  = 48;

  logic          busy, op_wr, flag;
  logic [4:0]    ra;
  logic [15:0]   rd;
  logic [63:0]   sh;
  logic [5:0]    bitcnt;
  logic [HW-1:0] hcnt;

  wire tick  = busy && (hcnt == HW'(HALF - 1));
  wire fall  = tick && mdc;
  wire rise  = tick && !mdc;
  wire start = host_we && !busy;
  wire wr_req = host_wdata[31];

  assign host_rdata = {flag, 10'b0, ra, rd};
  assign mdio_o     = busy ? sh[63] : 1'b1;
  assign mdio_oe    = busy && (op_wr || bitcnt < 6'(TA_BIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; op_wr <= 1'b0; flag <= 1'b0;
      ra <= '0; rd <= '0; sh <= '0; bitcnt <= '0; hcnt <= '0; mdc <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      op_wr  <= wr_req;
      flag   <= wr_req;
      ra     <= host_wdata[20:16];
      rd     <= host_wdata[15:0];
      bitcnt <= '0;
      hcnt   <= '0;
      mdc    <= 1'b0;
      sh     <= {32'hFFFF_FFFF, 2'b01, (wr_req ? 2'b01 : 2'b10), PHY_ADDR,
                 host_wdata[20:16],
                 (wr_req ? {2'b10, host_wdata[15:0]} : 18'h3FFFF)};
    end else if (busy) begin
      hcnt <= tick ? '0 : hcnt + 1'b1;
      if (tick) mdc <= !mdc;
      if (rise && !op_wr && bitcnt >= 6'(DAT_BIT))
        rd <= {rd[14:0], mdio_i};
      if (fall) begin
        sh     <= {sh[62:0], 1'b1};
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == 6'(LAST_BIT)) begin
          busy <= 1'b0;
          flag <= !op_wr;
        end
      end
    end
  end

  // R3
  write_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && host_wdata[31] |=> host_rdata[31] && busy);

  // R4
  read_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !host_wdata[31] |=> !host_rdata[31] && busy);

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && host_we && !fall |=> $stable(host_rdata[31:16]));

  // R7
  mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && (mdio_o != $past(mdio_o)) |-> $fell(mdc));

  // R7
  idle_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R9
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (host_rdata[31] != op_wr));
endmodule

// File: tb/phy_mgmt_bridge_tb.sv
module phy_mgmt_bridge_tb;
  localparam int DIV   = 8;
  localparam int FRAME = 64 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  int frames_seen = 0;
  int ridx = 0;
  logic [15:0] phy_val = '0;
  logic [64:0] exp_q[$];
  logic [64:0] cur;
  logic [63:0] cap, oecap, mask;
  time t_rise0 = 0;
  bit  period_checked = 0;

  always #2 clk = ~clk;

  phy_mgmt_bridge #(.CLK_DIV(DIV), .PHY_ADDR(5'd1)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [64:0] mk_frame(input logic wr, input logic [4:0] a, input logic [15:0] d);
    return {~wr, 32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), 5'd1, a,
            (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0000)};
  endfunction

  task automatic host_wr(input logic [31:0] w);
    @(negedge clk); host_we = 1'b1; host_wdata = w;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic issue(input logic wr, input logic [4:0] a, input logic [15:0] d);
    exp_q.push_back(mk_frame(wr, a, d));
    host_wr({wr, 10'b0, a, d});
  endtask

  // scoreboard monitor: capture each frame on rising mdc
  always @(posedge mdc) begin
    if (ridx == 0) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected frame actual=1 expected=0");
        cur = '0;
      end else cur = exp_q.pop_front();
      t_rise0 = $time;
    end
    if (ridx == 1 && !period_checked) begin
      period_checked = 1;
      chk("R7 mdc period", 32'($time - t_rise0), 32'(DIV * 4));
    end
    cap[63-ridx]   = mdio_o;
    oecap[63-ridx] = mdio_oe;
    if (ridx == 63) begin
      mask = cur[64] ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
      chk("R5 frame bits hi", (cap & mask) >> 32, (cur[63:0] & mask) >> 32);
      chk("R5 frame bits lo", 32'(cap & mask), 32'(cur[63:0] & mask));
      chk("R6 drive enable pattern", 32'(oecap), 32'(mask));
      frames_seen++;
      ridx = 0;
    end else ridx++;
  end

  // PHY model: answers read frames
  always @(negedge mdc) begin
    if (ridx >= 48 && ridx <= 63) mdio_i = phy_val[63-ridx];
    else if (ridx == 47)          mdio_i = 1'b0;
    else                          mdio_i = 1'b1;
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 rdata at reset", host_rdata, 32'h0);
    chk("R1 mdc/oe at reset", {30'b0, mdc, mdio_oe}, 32'h0);
    rst_n = 1'b1;

    // write, exact completion timing
    issue(1'b1, 5'h0B, 16'h0000);
    chk("R2 R3 layout and flag set", host_rdata, {1'b1, 10'b0, 5'h0B, 16'h0000});
    repeat (FRAME - 1) @(negedge clk);
    chk("R9 flag still set one clock early", 32'(host_rdata[31]), 32'h1);
    @(negedge clk);
    chk("R3 R9 flag cleared at end", host_rdata, {1'b0, 10'b0, 5'h0B, 16'h0000});

    // R10 back-to-back write
    issue(1'b1, 5'h1F, 16'hA55A);
    chk("R10 accepted right after completion", host_rdata, {1'b1, 10'b0, 5'h1F, 16'hA55A});
    repeat (FRAME) @(negedge clk);
    chk("R3 write done", host_rdata, {1'b0, 10'b0, 5'h1F, 16'hA55A});

    // reads
    phy_val = 16'h1234;
    issue(1'b0, 5'h02, 16'h0000);
    chk("R4 flag clear on read start", 32'(host_rdata[31]), 32'h0);
    repeat (FRAME - 1) @(negedge clk);
    chk("R9 read flag still clear", 32'(host_rdata[31]), 32'h0);
    @(negedge clk);
    chk("R4 R6 read data", host_rdata, {1'b1, 10'b0, 5'h02, 16'h1234});

    phy_val = 16'h8001;
    issue(1'b0, 5'h10, 16'hFFFF);
    repeat (FRAME) @(negedge clk);
    chk("R6 read MSB/LSB", host_rdata, {1'b1, 10'b0, 5'h10, 16'h8001});

    // ignored write while busy
    issue(1'b1, 5'h05, 16'hBEEF);
    repeat (100) @(negedge clk);
    host_wr({1'b0, 10'b0, 5'h1A, 16'h0000});
    chk("R8 upper half unchanged", 32'(host_rdata[31:16]), 32'({1'b1, 10'b0, 5'h05}));
    repeat (FRAME - 102) @(negedge clk);
    chk("R8 write completes intact", host_rdata, {1'b0, 10'b0, 5'h05, 16'hBEEF});
    repeat (FRAME) @(negedge clk);
    chk("R8 no extra frame", 32'(frames_seen), 32'd5);
    chk("R7 mdc idle low", 32'(mdc), 32'h0);
    chk("R5 all expected frames seen", 32'(exp_q.size()), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule